// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic stage of a 16-bit datapath. It computes its result without a clock, from two operands and a 4-bit operation code. It can work on full words, or on bytes taken from the low half of each operand. Alongside the result it keeps a registered four-bit status word. That word records the zero, negative, carry and overflow conditions of the last operation that was allowed to update it, so later branch logic can test both signed and unsigned conditions.

Multi-precision add and subtract work by chaining. The add-with-carry and subtract-with-borrow operations take their carry input from the carry bit stored in the status register, which holds the carry of the previous partial result. In byte mode the upper half of the result is taken unchanged from operand A. The flags then describe only the low byte. A sign-extension operation widens a byte into a word for later word-wide arithmetic.

Top module: `alu_bw_core`

## Requirements
- R1: Opcode 0 (add), word mode: res_o = (a_i + b_i) mod 2^16. Carry (flags_o bit 0) is the carry out of bit 15. Overflow (bit 1) is set when both operands have the same sign and the result's sign differs. Zero (bit 2) and negative (bit 3) describe the result.
- R2: With byte_i = 1, every opcode except 9 places the 8-bit operation result in res_o[7:0] and copies a_i[15:8] into res_o[15:8]. Zero is then taken from bits 7:0 only, negative from bit 7, carry from the carry out of bit 7, and overflow from the carries into and out of bit 7.
- R3: Opcode 2 (subtract) gives a_i - b_i. Carry means borrow: it is set when the unsigned a_i is smaller than b_i. Overflow is set when the operand signs differ and the result's sign differs from a_i.
- R4: Opcode 1 (add with carry) adds the stored carry flag as a carry-in. Opcode 3 (subtract with borrow) subtracts the stored carry flag as a borrow-in. This lets two operations chain into a 32-bit add or subtract.
- R5: Opcodes 4, 5 and 6 (AND, OR, XOR) give the bitwise result. They clear carry and overflow, and set zero and negative from the result.
- R6: Opcode 7 (compare) sets all four flags exactly as subtract does, while res_o shows a_i unchanged.
- R7: Opcode 8 (move) gives b_i as the result. It clears carry and overflow, and sets zero and negative from the result.
- R8: Opcode 9 (sign extend) gives {8 copies of a_i[7], a_i[7:0]} whatever the value of byte_i. It sets zero and negative from the 16-bit result and clears carry and overflow.
- R9: The status register (bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative) loads only on a rising clk edge where flag_we_i is 1. Otherwise it holds its value.
- R10: Opcodes 10 to 15 give a_i as the result and leave the status register unchanged, even with flag_we_i = 1.
- R11: A synchronous active-high rst clears the status register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = operate on the low byte |
| flag_we_i | input | 1 | Status register load enable |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| res_o | output | 16 | Combinational result |
| flags_o | output | 4 | Registered status word {N, Z, V, C} |

## Verification
The properties assume that op_i, byte_i and flag_we_i are steady over each clock edge. They also assume the operands are known, never X, whenever a result or flag is compared. The bench changes inputs only on falling edges and applies each operation for exactly one rising edge. It then drops the enable, so every flag update can be traced to a single operation. All stimulus uses fully specified operand values. The opcodes cover the whole 4-bit range, including the six unused codes.

// File: rtl/alu_bw_pkg.sv
package alu_bw_pkg;
  localparam int FLAG_W = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_MOV  = 4'd8,
    OP_SEXT = 4'd9
  } op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu_bw_addsub.sv
module alu_bw_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cflag,
  output logic         ovf
);
  logic [W-1:0] bx;
  logic         ci;
  logic [W:0]   t;

  always_comb begin
    bx    = sub ? ~b : b;
    ci    = sub ? ~cin : cin;
    t     = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    sum   = t[W-1:0];
    cflag = sub ? ~t[W] : t[W];
    ovf   = (a[W-1] == bx[W-1]) && (t[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_bw_logic.sv
module alu_bw_logic #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import alu_bw_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MOV:  res = b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_bw_flagreg.sv
module alu_bw_flagreg (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                valid,
  input  alu_bw_pkg::flags_t  d,
  output alu_bw_pkg::flags_t  q
);
  always_ff @(posedge clk) begin
    if (rst)              q <= '0;
    else if (we && valid) q <= d;
  end
endmodule

// File: rtl/alu_bw_core.sv
module alu_bw_core #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic          byte_i,
  input  logic          flag_we_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic [3:0]    flags_o
);
  import alu_bw_pkg::*;

  localparam int HW = DW - BW;

  flags_t        flags_q, flags_d;
  logic          is_arith, is_sub, use_cin, cin, lane_byte, valid;
  logic [DW-1:0] wsum, lres, fval, res_c;
  logic [BW-1:0] bsum;
  logic          wc, wv, bc, bv;

  always_comb begin
    is_arith  = (op_i == OP_ADD) || (op_i == OP_ADDC) || (op_i == OP_SUB) ||
                (op_i == OP_SUBC) || (op_i == OP_CMP);
    is_sub    = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    use_cin   = (op_i == OP_ADDC) || (op_i == OP_SUBC);
    cin       = use_cin & flags_q.c;
    lane_byte = byte_i && (op_i != OP_SEXT);
    valid     = (op_i <= OP_LAST);
  end

  alu_bw_addsub #(.W(DW)) u_add_word (
    .a(a_i), .b(b_i), .sub(is_sub), .cin(cin),
    .sum(wsum), .cflag(wc), .ovf(wv)
  );

  alu_bw_addsub #(.W(BW)) u_add_byte (
    .a(a_i[BW-1:0]), .b(b_i[BW-1:0]), .sub(is_sub), .cin(cin),
    .sum(bsum), .cflag(bc), .ovf(bv)
  );

  alu_bw_logic #(.W(DW)) u_logic (
    .op(op_i), .a(a_i), .b(b_i), .res(lres)
  );

  always_comb begin
    if (is_arith)
      fval = lane_byte ? {a_i[DW-1:BW], bsum} : wsum;
    else if (op_i == OP_SEXT)
      fval = {{HW{a_i[BW-1]}}, a_i[BW-1:0]};
    else
      fval = lane_byte ? {a_i[DW-1:BW], lres[BW-1:0]} : lres;

    res_c = ((op_i == OP_CMP) || !valid) ? a_i : fval;

    flags_d.z = lane_byte ? (fval[BW-1:0] == '0) : (fval == '0);
    flags_d.n = lane_byte ? fval[BW-1] : fval[DW-1];
    flags_d.c = is_arith & (lane_byte ? bc : wc);
    flags_d.v = is_arith & (lane_byte ? bv : wv);
  end

  alu_bw_flagreg u_flags (
    .clk(clk), .rst(rst), .we(flag_we_i), .valid(valid),
    .d(flags_d), .q(flags_q)
  );

  assign res_o   = res_c;
  assign flags_o = flags_q;
endmodule

// File: rtl/alu_bw_chk.sv
module alu_bw_chk #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op_i,
  input logic          byte_i,
  input logic          flag_we_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] res_o,
  input logic [3:0]    flags_o
);
  localparam int HW = DW - BW;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  p_unused_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i > 4'd9) |=> $stable(flags_o));

  p_unused_res_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i > 4'd9) |-> res_o == a_i);

  p_logic_cv_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> flags_o[1:0] == 2'b00);

  p_byte_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (byte_i && op_i != 4'd9) |-> res_o[DW-1:BW] == a_i[DW-1:BW]);

  p_cmp_res_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7) |-> res_o == a_i);

  p_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9) |-> res_o[DW-1:BW] == {HW{a_i[BW-1]}});

  p_reset_r11: assert property (@(posedge clk)
    rst |=> flags_o == 4'd0);
endmodule

bind alu_bw_core alu_bw_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .byte_i(byte_i), .flag_we_i(flag_we_i),
  .a_i(a_i), .b_i(b_i), .res_o(res_o), .flags_o(flags_o)
);

// File: tb/test_alu_bw_core.sv
module test_alu_bw_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'd0;
  logic        byte_i = 1'b0;
  logic        flag_we_i = 1'b0;
  logic [15:0] a_i = 16'd0;
  logic [15:0] b_i = 16'd0;
  logic [15:0] res_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] mflags = 4'd0;

  always #(CLK_P/2) clk = ~clk;

  alu_bw_core i_alu_bw_core (
    .clk(clk), .rst(rst), .op_i(op_i), .byte_i(byte_i), .flag_we_i(flag_we_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic byt,
                                input logic [15:0] a, input logic [15:0] b,
                                input logic cf, output logic [15:0] r,
                                output logic [3:0] fl, output logic upd);
    int w, mask, av, bv, s, lr;
    logic c, v, n, z;
    upd = (op <= 4'd9);
    w = (byt && op != 4'd9) ? 8 : 16;
    mask = (1 << w) - 1;
    av = int'(a) & mask;
    bv = int'(b) & mask;
    c = 1'b0; v = 1'b0; lr = av;
    case (op)
      4'd0, 4'd1: begin
        s = av + bv + ((op == 4'd1) ? int'(cf) : 0);
        c = ((s >> w) & 1) != 0;
        lr = s & mask;
        v = ((av >> (w-1)) == (bv >> (w-1))) && ((lr >> (w-1)) != (av >> (w-1)));
      end
      4'd2, 4'd3, 4'd7: begin
        s = av - bv - ((op == 4'd3) ? int'(cf) : 0);
        c = (s < 0);
        lr = s & mask;
        v = ((av >> (w-1)) != (bv >> (w-1))) && ((lr >> (w-1)) != (av >> (w-1)));
      end
      4'd4: lr = av & bv;
      4'd5: lr = av | bv;
      4'd6: lr = av ^ bv;
      4'd8: lr = bv;
      4'd9: lr = a[7] ? (int'(a[7:0]) | 32'hFF00) : int'(a[7:0]);
      default: lr = av;
    endcase
    z = (lr == 0);
    n = ((lr >> (w-1)) & 1) != 0;
    if (op == 4'd7 || op > 4'd9) r = a;
    else if (w == 8)             r = {a[15:8], lr[7:0]};
    else                         r = lr[15:0];
    fl = {n, z, v, c};
  endfunction

  task automatic apply(input string req, input logic [3:0] op, input logic byt,
                       input logic [15:0] a, input logic [15:0] b, input logic we);
    logic [15:0] er;
    logic [3:0]  ef;
    logic        upd;
    @(negedge clk);
    op_i = op; byte_i = byt; a_i = a; b_i = b; flag_we_i = we;
    #1;
    model(op, byt, a, b, mflags[0], er, ef, upd);
    chk({req, " result"}, res_o, er);
    if (we && upd) mflags = ef;
    @(negedge clk);
    chk({req, " flags"}, {12'd0, flags_o}, {12'd0, mflags});
    flag_we_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 reset", {12'd0, flags_o}, 16'd0);
    rst = 1'b0;
    apply("R11 set", 4'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mflags = 4'd0;
    chk("R11 reset clears", {12'd0, flags_o}, 16'd0);
  endtask

  task automatic t_word_add();
    apply("R1 ovf", 4'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b1);
    apply("R1 carry zero", 4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1);
    apply("R1 plain", 4'd0, 1'b0, 16'h1234, 16'h1111, 1'b1);
  endtask

  task automatic t_byte();
    apply("R2 byte ovf", 4'd0, 1'b1, 16'hAB7F, 16'h0001, 1'b1);
    apply("R2 byte carry zero", 4'd0, 1'b1, 16'h12FF, 16'h3401, 1'b1);
    apply("R2 byte borrow", 4'd2, 1'b1, 16'h5500, 16'h0001, 1'b1);
    apply("R2 byte xor", 4'd6, 1'b1, 16'hC3A5, 16'hFFA5, 1'b1);
  endtask

  task automatic t_sub();
    apply("R3 no borrow", 4'd2, 1'b0, 16'h0005, 16'h0003, 1'b1);
    apply("R3 borrow", 4'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    apply("R3 ovf", 4'd2, 1'b0, 16'h8000, 16'h0001, 1'b1);
  endtask

  task automatic t_chain();
    apply("R4 add low", 4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1);
    apply("R4 addc high", 4'd1, 1'b0, 16'h0001, 16'h0000, 1'b1);
    apply("R4 sub low", 4'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    apply("R4 subc high", 4'd3, 1'b0, 16'h0005, 16'h0000, 1'b1);
    apply("R4 byte addc", 4'd0, 1'b1, 16'h00FF, 16'h0001, 1'b1);
    apply("R4 byte addc2", 4'd1, 1'b1, 16'h0010, 16'h0020, 1'b1);
  endtask

  task automatic t_logic();
    apply("R5 prep", 4'd0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R5 and", 4'd4, 1'b0, 16'hF0F0, 16'h0FF0, 1'b1);
    apply("R5 or zero", 4'd5, 1'b0, 16'h0000, 16'h0000, 1'b1);
    apply("R5 xor neg", 4'd6, 1'b0, 16'hFFFF, 16'h0F0F, 1'b1);
  endtask

  task automatic t_cmp_mov();
    apply("R6 cmp", 4'd7, 1'b0, 16'h0003, 16'h0005, 1'b1);
    apply("R6 cmp eq", 4'd7, 1'b1, 16'h9944, 16'h0044, 1'b1);
    apply("R7 mov word", 4'd8, 1'b0, 16'h1111, 16'h8001, 1'b1);
    apply("R7 mov byte", 4'd8, 1'b1, 16'h2222, 16'h7700, 1'b1);
  endtask

  task automatic t_sext();
    apply("R8 neg", 4'd9, 1'b0, 16'h1280, 16'h0000, 1'b1);
    apply("R8 pos byte", 4'd9, 1'b1, 16'hFF7F, 16'h0000, 1'b1);
    apply("R8 zero", 4'd9, 1'b0, 16'hAB00, 16'h0000, 1'b1);
  endtask

  task automatic t_hold();
    apply("R9 set", 4'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    apply("R9 hold add", 4'd0, 1'b0, 16'h0001, 16'h0001, 1'b0);
    apply("R9 hold and", 4'd4, 1'b0, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_unused();
    apply("R10 prep", 4'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b1);
    for (int k = 10; k < 16; k++)
      apply("R10 unused", 4'(k), k[0], 16'h0000 + 16'(k), 16'hFFFF, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_word_add();
    t_byte();
    t_sub();
    t_chain();
    t_logic();
    t_cmp_mov();
    t_sext();
    t_hold();
    t_unused();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule